// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is a standard-mode I2C target that holds seven 8-bit control registers at indices 00h to 06h. It sees the bus through oversampled SCL and SDA inputs in the system clock domain. Each line passes through a two-flop synchroniser, and edges and bus conditions are detected after it. The block answers by pulling SDA low through an open-drain enable. A host writes a pointer byte and then a run of data bytes. It reads either from the current pointer, or from a chosen index by writing the pointer and then issuing a repeated START.

The upper five bits of the 7-bit target address are fixed at 00100. The two low bits come from strap inputs. An internal 5-bit pointer advances after every data byte, whether written or read, and returns from 06h to 00h. While the active-low power-down input is low, the registers are held at their default values and writes have no effect. The bus protocol keeps running in that time, so bytes are still acknowledged.

The control is one state machine. Its states are: IDLE (bus free), ADDR (shifting the address byte), ADDR_ACK (acknowledging the address), PTR (shifting the pointer byte), PTR_ACK, WDATA (shifting a write byte), WDATA_ACK, RDATA (driving a read byte), RDATA_ACK (sampling the controller's answer) and IGNORE (not addressed, or reading has ended). The transitions are as follows:
- START from any state goes to ADDR, and STOP from any state goes to IDLE.
- ADDR goes to ADDR_ACK on an address match, otherwise to IGNORE.
- ADDR_ACK goes to RDATA for a read and to PTR for a write.
- PTR goes to PTR_ACK and then to WDATA.
- WDATA goes to WDATA_ACK and back to WDATA.
- RDATA goes to RDATA_ACK. RDATA_ACK goes back to RDATA on ACK and to IGNORE on NACK.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset the registers read 80h, 20h, 00h, 10h, 10h, 10h, 10h for indices 0 to 6 (cfg_regs bits [8i+7:8i] hold index i), and SDA is released.
- R2: The target acknowledges an address byte only when its upper seven bits equal {00100, strap_a[1], strap_a[0]}. Bit 0 of that byte is R/W, with 1 meaning read. On a mismatch SDA stays released and further bytes are neither acknowledged nor stored until the next START.
- R3: SDA falling while SCL is high is a START, which begins a new address byte from any state, including in the middle of a byte. SDA rising while SCL is high is a STOP, which returns the target to IDLE.
- R4: In a write, the byte after the address loads the pointer from its low five bits. Each later byte is stored at the pointer and acknowledged.
- R5: After every data byte, written or read, the pointer advances by one. From 06h it goes to 00h.
- R6: A read without a preceding pointer write returns the register at the pointer left by the last access, then advances the pointer.
- R7: A random read (pointer write, repeated START, address with R/W = 1) returns the register at the written pointer.
- R8: In a read, the target sends the next byte after an ACK from the controller. After a NACK it leaves SDA released until the next START or STOP.
- R9: Reading at a pointer above 06h returns 00h. Writing there changes no register.
- R10: While pwrdn_n is low the registers hold their defaults and writes are dropped, although bytes are still acknowledged.
- R11: SDA is only ever pulled low, never driven high, and the pull-down enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Active-low power-down; holds registers at defaults |
| strap_a | input | 2 | Strapped low two bits of the target address |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| cfg_regs | output | 56 | All seven registers, index i at bits [8i+7:8i] |

## Verification
Some properties are checked on every cycle:
- The pull-down enable only changes after SCL has been seen low, and it stays off in IDLE and IGNORE.
- Any register change follows the final bit of a write byte.
- Power-down forces the defaults.
- Every pointer step is either a pointer-byte load or a +1 with the 06h to 00h wrap.
- A START always leads into the address state.

Other behaviours can only be shown by bench scenarios, because they are about what the bus returns over whole transactions. These include:
- which addresses are acknowledged, across all strap values;
- the order of data in write bursts and current-address reads that cross the wrap;
- random reads of every index, including the 00h returned above 06h;
- the release after a NACK;
- a START that cuts off a byte part way through.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } tgt_state_t;

    // Power-on value of register index idx.
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h80;
            1:       return 8'h20;
            2:       return 8'h00;
            default: return 8'h10;
        endcase
    endfunction

endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_prev
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain  <= '1;
            q_prev <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], d};
            q_prev <= chain[STAGES-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile
    import i2c_cfg_pkg::*;
#(
    parameter int NREG  = 7,
    parameter int DW    = 8,
    parameter int PTR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwrdn_n,
    input  logic                 wr_en,
    input  logic [PTR_W-1:0]     wr_idx,
    input  logic [DW-1:0]        wr_data,
    input  logic [PTR_W-1:0]     rd_idx,
    output logic [DW-1:0]        rd_data,
    output logic [NREG*DW-1:0]   reg_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r <= DW'(reg_default(g));
            end else if (!pwrdn_n) begin
                r <= DW'(reg_default(g));
            end else if (wr_en && wr_idx == PTR_W'(g)) begin
                r <= wr_data;
            end
        end
        assign reg_flat[g*DW +: DW] = r;
    end

    // Indices past the last register read back as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx == PTR_W'(i)) rd_data = reg_flat[i*DW +: DW];
        end
    end
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_cfg_pkg::*;
#(
    parameter logic [4:0] ADDR_HI     = 5'b00100,
    parameter int         NREG        = 7,
    parameter int         DW          = 8,
    parameter int         PTR_W       = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwrdn_n,
    input  logic [1:0]         strap_a,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_drive_low,
    output logic [NREG*DW-1:0] cfg_regs
);
    localparam int               CNT_W    = $clog2(DW + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NREG - 1);

    // Line conditioning and bus events
    logic scl_s, scl_p, sda_s, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;

    i2c_cfg_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s), .q_prev(scl_p));
    i2c_cfg_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s), .q_prev(sda_p));

    assign scl_rise  =  scl_s && !scl_p;
    assign scl_fall  = !scl_s &&  scl_p;
    assign start_det =  scl_s &&  scl_p &&  sda_p && !sda_s;
    assign stop_det  =  scl_s &&  scl_p && !sda_p &&  sda_s;

    // Controller state
    tgt_state_t       state, state_nx;
    logic [DW-1:0]    shreg;
    logic [CNT_W-1:0] bitcnt;
    logic             ack_phase;
    logic             rw_bit;
    logic             mack;
    logic [PTR_W-1:0] ptr;
    logic [DW-1:0]    rd_data;
    logic [DW-1:0]    byte_in;
    logic             last_bit;
    logic             addr_hit;
    logic             wr_en;
    logic [PTR_W-1:0] ptr_inc;

    assign byte_in  = {shreg[DW-2:0], sda_s};
    assign last_bit = scl_rise && (bitcnt == CNT_W'(DW - 1));
    assign addr_hit = (byte_in[DW-1:DW-7] == {ADDR_HI, strap_a});
    assign wr_en    = (state == ST_WDATA) && last_bit;
    assign ptr_inc  = (ptr == LAST_IDX) ? '0 : ptr + 1'b1;

    i2c_cfg_regfile #(.NREG(NREG), .DW(DW), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
        .wr_en(wr_en), .wr_idx(ptr), .wr_data(byte_in),
        .rd_idx(ptr), .rd_data(rd_data), .reg_flat(cfg_regs));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (last_bit) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall && ack_phase) state_nx = rw_bit ? ST_RDATA : ST_PTR;
                ST_PTR:       if (last_bit) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall && ack_phase) state_nx = ST_WDATA;
                ST_WDATA:     if (last_bit) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall && ack_phase) state_nx = ST_WDATA;
                ST_RDATA:     if (scl_fall && bitcnt == CNT_W'(DW)) state_nx = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) state_nx = mack ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_nx = ST_IGNORE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // Datapath and open-drain output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg         <= '0;
            bitcnt        <= '0;
            ack_phase     <= 1'b0;
            rw_bit        <= 1'b0;
            mack          <= 1'b0;
            ptr           <= '0;
            sda_drive_low <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt        <= '0;
            ack_phase     <= 1'b0;
            sda_drive_low <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= byte_in;
                        bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
                        if (last_bit) begin
                            if (state == ST_ADDR)  rw_bit <= byte_in[DW-8];
                            if (state == ST_PTR)   ptr    <= byte_in[PTR_W-1:0];
                            if (state == ST_WDATA) ptr    <= ptr_inc;
                        end
                    end
                end
                ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        if (!ack_phase) begin
                            ack_phase     <= 1'b1;
                            sda_drive_low <= 1'b1;
                        end else begin
                            ack_phase <= 1'b0;
                            bitcnt    <= '0;
                            if (state == ST_ADDR_ACK && rw_bit) begin
                                shreg         <= rd_data;
                                sda_drive_low <= !rd_data[DW-1];
                                ptr           <= ptr_inc;
                            end else begin
                                sda_drive_low <= 1'b0;
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bitcnt == CNT_W'(DW)) begin
                            sda_drive_low <= 1'b0;
                        end else begin
                            shreg         <= shreg << 1;
                            sda_drive_low <= !shreg[DW-2];
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        mack <= !sda_s;
                    end else if (scl_fall && mack) begin
                        shreg         <= rd_data;
                        sda_drive_low <= !rd_data[DW-1];
                        ptr           <= ptr_inc;
                        bitcnt        <= '0;
                    end
                end
                ST_IDLE, ST_IGNORE: sda_drive_low <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cfg_target_chk.sv
module i2c_cfg_target_chk
    import i2c_cfg_pkg::*;
#(
    parameter int NREG  = 7,
    parameter int DW    = 8,
    parameter int PTR_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pwrdn_n,
    input logic               scl_s,
    input logic               scl_rise,
    input logic               start_det,
    input logic               sda_drive_low,
    input logic [NREG*DW-1:0] cfg_regs,
    input tgt_state_t         state,
    input logic [PTR_W-1:0]   ptr
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NREG - 1);

    function automatic logic [NREG*DW-1:0] defaults_vec();
        logic [NREG*DW-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*DW +: DW] = DW'(reg_default(i));
        return v;
    endfunction

    localparam logic [NREG*DW-1:0] DEF_VEC = defaults_vec();

    AST_PD_HOLDS_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwrdn_n) |-> cfg_regs == DEF_VEC); // R10

    AST_REGS_CHANGE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cfg_regs) && $past(pwrdn_n)) |-> ($past(scl_rise) && $past(state) == ST_WDATA)); // R4

    AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr) && $past(state) != ST_PTR) |->
            ptr == (($past(ptr) == LAST_IDX) ? '0 : PTR_W'($past(ptr) + 1'b1))); // R5

    AST_DRIVE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !$past(scl_s)); // R11

    AST_QUIET_WHEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_drive_low); // R2

    AST_START_ENTERS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == ST_ADDR); // R3
endmodule

bind i2c_cfg_target i2c_cfg_target_chk #(.NREG(NREG), .DW(DW), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .scl_s(scl_s), .scl_rise(scl_rise),
    .start_det(start_det), .sda_drive_low(sda_drive_low), .cfg_regs(cfg_regs),
    .state(state), .ptr(ptr));

// File: tb/i2c_cfg_target_test.sv
module i2c_cfg_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrdn_n = 1'b1;
    logic [1:0]  strap = 2'b10;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        drv;
    logic [55:0] regs;
    wire         sda_line = sda_m & ~drv;

    int errors = 0;
    int checks = 0;
    int od_viol = 0;
    logic [7:0] exp_reg [7];
    logic [4:0] exp_ptr = 5'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cfg_target uut (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .strap_a(strap),
        .scl_in(scl_m), .sda_in(sda_line), .sda_drive_low(drv), .cfg_regs(regs));

    // Open-drain monitor: the enable must not move while SCL is high (R11)
    logic drv_q = 1'b0;
    always @(negedge clk) begin
        if (rst_n && drv !== drv_q && scl_m) od_viol++;
        drv_q <= drv;
    end

    function automatic logic [7:0] dflt(input int i);
        return (i == 0) ? 8'h80 : (i == 1) ? 8'h20 : (i == 2) ? 8'h00 : 8'h10;
    endfunction

    function automatic logic [4:0] nxt(input logic [4:0] p);
        return (p == 5'd6) ? 5'd0 : p + 5'd1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            d[i] = sda_line; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = !give_ack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < 7; i++)
            check($sformatf("%s reg%0d", tag, i), int'(regs[i*8 +: 8]), int'(exp_reg[i]));
    endtask

    // Pointer write followed by n data bytes; model follows R4/R5/R9/R10.
    task automatic wr_burst(input logic [4:0] p, input int n, input logic [7:0] seed, input string tag);
        bit ack;
        bus_start();
        send_byte({5'b00100, strap, 1'b0}, ack); check({tag, " addr ack"}, ack, 1);
        send_byte({3'b000, p}, ack);             check({tag, " ptr ack"}, ack, 1);
        exp_ptr = p;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = seed + 8'(i * 8'h13);
            send_byte(d, ack); check({tag, " data ack"}, ack, 1);
            if (pwrdn_n && exp_ptr <= 5'd6) exp_reg[exp_ptr] = d;
            exp_ptr = nxt(exp_ptr);
        end
        bus_stop();
    endtask

    // Optional pointer write plus repeated START, then n read bytes, NACK on the last.
    task automatic rd_burst(input bit set_ptr, input logic [4:0] p, input int n, input string tag);
        bit ack;
        logic [7:0] d;
        bus_start();
        if (set_ptr) begin
            send_byte({5'b00100, strap, 1'b0}, ack); check({tag, " R7 addr ack"}, ack, 1);
            send_byte({3'b000, p}, ack);             check({tag, " R7 ptr ack"}, ack, 1);
            exp_ptr = p;
            bus_start();
        end
        send_byte({5'b00100, strap, 1'b1}, ack); check({tag, " read addr ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            check($sformatf("%s data ptr=%0d", tag, exp_ptr), int'(d),
                  (exp_ptr <= 5'd6) ? int'(exp_reg[exp_ptr]) : 0);
            exp_ptr = nxt(exp_ptr);
        end
        // After NACK the line stays released for a further SCL pulse (R8)
        tick(Q);
        check({tag, " R8 released after NACK"}, int'(drv), 0);
        send_bits(8'hFF, 1);
        check({tag, " R8 line high after NACK"}, int'(sda_line), 1);
        bus_stop();
    endtask

    initial begin
        bit ack;
        for (int i = 0; i < 7; i++) exp_reg[i] = dflt(i);
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        check_regs("R1 reset");
        check("R1 sda released", int'(drv), 0);

        // R2 full sweep of the 7-bit address space with the current strap
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            bus_stop();
            check($sformatf("R2 addr %02h ack", a), ack,
                  (7'(a) == {5'b00100, strap}) ? 1 : 0);
        end
        // R2 every strap against every low-bit pair
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            tick(4);
            for (int lo = 0; lo < 4; lo++) begin
                bus_start();
                send_byte({5'b00100, 2'(lo), 1'b0}, ack);
                bus_stop();
                check($sformatf("R2 strap %0d low %0d ack", s, lo), ack, (lo == s) ? 1 : 0);
            end
        end
        strap = 2'b01;
        tick(4);
        // R2 mismatched transaction leaves registers untouched
        bus_start();
        send_byte({5'b00100, 2'b11, 1'b0}, ack); check("R2 mismatch nack", ack, 0);
        send_byte(8'h00, ack);                   check("R2 ignored ptr nack", ack, 0);
        send_byte(8'hEE, ack);                   check("R2 ignored data nack", ack, 0);
        bus_stop();
        check_regs("R2 mismatch no write");

        // R4 R5 write burst crossing 06h -> 00h
        wr_burst(5'd4, 6, 8'hA1, "R4 R5 burst");
        check_regs("R4 R5 burst regs");

        // R6 current-address read from the pointer left by the burst
        rd_burst(1'b0, 5'd0, 2, "R6 current");

        // R7 R9 random read of every index, plus two above the last
        for (int p = 0; p < 9; p++) rd_burst(1'b1, 5'(p), 1, "R7 R9 random");
        rd_burst(1'b1, 5'd20, 1, "R9 high ptr");

        // R5 R8 multi-byte read across the wrap
        rd_burst(1'b1, 5'd5, 4, "R5 R8 wrap read");

        // R9 write above the last index changes nothing
        wr_burst(5'd7, 1, 8'h5A, "R9 high write");
        check_regs("R9 high write regs");

        // R3 START in the middle of a byte restarts the address phase
        bus_start();
        send_byte({5'b00100, strap, 1'b0}, ack); check("R3 addr ack", ack, 1);
        send_byte(8'h00, ack);                   check("R3 ptr ack", ack, 1);
        send_bits(8'h55, 4);
        bus_start();
        send_byte({5'b00100, strap, 1'b0}, ack); check("R3 restart addr ack", ack, 1);
        send_byte(8'h01, ack);                   check("R3 restart ptr ack", ack, 1);
        send_byte(8'h3C, ack);                   check("R3 restart data ack", ack, 1);
        bus_stop();
        exp_reg[1] = 8'h3C;
        exp_ptr = 5'd2;
        check_regs("R3 partial byte dropped");

        // R10 power-down holds defaults and drops writes
        pwrdn_n = 1'b0;
        tick(4);
        for (int i = 0; i < 7; i++) exp_reg[i] = dflt(i);
        check_regs("R10 pd defaults");
        wr_burst(5'd0, 3, 8'h77, "R10 pd write");
        check_regs("R10 pd write dropped");
        pwrdn_n = 1'b1;
        tick(4);
        rd_burst(1'b1, 5'd1, 3, "R10 after pd");
        wr_burst(5'd2, 1, 8'h99, "R10 resumed write");
        check_regs("R10 resumed regs");

        // R11 open-drain enable only moved while SCL was low
        check("R11 enable changes with SCL high", od_viol, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule